// File: doc/BRIEF.md
# Message-Signalled Interrupt File (single context)

This block stores the pending and enable state of one interrupt context for identities 1 to N-1, where N is a parameter and a multiple of 64. A single-cycle strobe that carries an identity number marks that identity pending. This is how an incoming message-signalled interrupt is recorded once the bus has decoded it. Software sees the state through a small register port. It holds a delivery switch, a priority threshold, a top-identity view that can be claimed, and 32-bit pending and enable words.

A combinational scan picks the lowest-numbered identity that is pending, enabled and below the effective threshold limit. A registered request line goes high when delivery is switched on and that scan finds an identity. Writing anything to the top-identity register claims the interrupt, which clears the pending bit of the identity found.

Register selects on `reg_sel`: 0x01 delivery switch, 0x02 threshold, 0x03 top identity, 0x40+k pending word k, 0x80+k enable word k. Word k covers identities 32k to 32k+31, with bit b standing for identity 32k+b. A select that matches none of these reads zero, and a write to it does nothing.

Top module: `msi_intr_file`

## Requirements
- R1: After a synchronous reset, every pending bit, every enable bit, the threshold and the delivery switch are zero. `irq` is low, and every register reads zero.
- R2: Identity 0 never holds state. Bit 0 of pending word 0 and bit 0 of enable word 0 always read zero. Register writes to those bits are ignored, and so is a strobe that carries identity 0.
- R3: When `msi_valid` is high and `msi_id` is in 1..N-1, that identity's pending bit is set at the next clock edge. A strobe that carries an identity of N or more changes nothing.
- R4: A write to a pending or enable word updates only the bits set in `reg_wmask`, each taking the value of the matching `reg_wdata` bit. During the write cycle, `reg_rdata` shows the old word value.
- R5: The top-identity register reads as the identity in bits 26:16 and again in bits 10:0, with all other bits zero. The identity is the lowest-numbered one that is both pending and enabled and that lies below the effective limit. The register reads 0 when no identity qualifies.
- R6: The threshold is an 11-bit register, and its upper bits read zero. When it is nonzero and no greater than N, only identities strictly below it qualify. When it is zero or greater than N, all identities qualify.
- R7: Any write to the top-identity register ignores `reg_wdata` and `reg_wmask`. It clears the pending bit of the current top identity. If the top identity is 0, the write has no effect.
- R8: The delivery switch keeps only bit 0 of a write, and its bits 31:1 read zero.
- R9: `irq` is a register. At each clock edge it takes the value (delivery switch AND top identity nonzero) as seen before that edge, so it follows any state change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | Set-pending strobe |
| msi_id | input | 11 | Identity carried by the strobe |
| reg_sel | input | 8 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wmask | input | 32 | Per-bit write mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current value of the selected register |
| irq | output | 1 | External interrupt request |

## Verification
The bench targets identity 0, threshold values equal to a pending identity, zero and above N, strobes carrying identity N, and claims made when nothing qualifies. A design with an off-by-one in the limit would still report identity 5 when the threshold is 5. A design that did not guard the zero-identity bit would read 0xFFFFFFFF back from enable word 0. The bench also times `irq` to the cycle: it must stay low at the first sample after the delivery write and rise at the next, so a combinational or doubly registered request line fails. It checks that a masked write returns the old word and that a claim with no qualifying identity leaves a below-limit pending bit untouched.

// File: rtl/mif_pkg.sv
package mif_pkg;
    localparam int DW     = 32;
    localparam int SEL_W  = 8;
    localparam int TOP_W  = 11;
    localparam int LIM_W  = TOP_W + 1;

    localparam logic [SEL_W-1:0] SEL_DELIV  = 8'h01;
    localparam logic [SEL_W-1:0] SEL_THRESH = 8'h02;
    localparam logic [SEL_W-1:0] SEL_TOP    = 8'h03;

    typedef enum logic [2:0] {
        K_NONE, K_DELIV, K_THRESH, K_TOP, K_PEND, K_ENAB
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e  kind;
        logic [5:0] word;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] s);
        sel_dec_t d;
        d.word = s[5:0];
        unique case (s[7:6])
            2'b01:   d.kind = K_PEND;
            2'b10:   d.kind = K_ENAB;
            2'b00: begin
                if (s == SEL_DELIV)       d.kind = K_DELIV;
                else if (s == SEL_THRESH) d.kind = K_THRESH;
                else if (s == SEL_TOP)    d.kind = K_TOP;
                else                      d.kind = K_NONE;
            end
            default: d.kind = K_NONE;
        endcase
        return d;
    endfunction

    function automatic logic [DW-1:0] pack_top(input logic [TOP_W-1:0] id);
        return {5'b0, id, 5'b0, id};
    endfunction
endpackage

// File: rtl/mif_bitarray.sv
module mif_bitarray
    import mif_pkg::*;
#(
    parameter int N = 64,
    localparam int NW = N / DW,
    localparam int WI_W = $clog2(NW),
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WI_W-1:0] wr_word,
    input  logic [DW-1:0]   wr_mask,
    input  logic [DW-1:0]   wr_data,
    input  logic            set_en,
    input  logic [ID_W-1:0] set_idx,
    input  logic            clr_en,
    input  logic [ID_W-1:0] clr_idx,
    input  logic [WI_W-1:0] rd_word,
    output logic [DW-1:0]   rd_data,
    output logic [N-1:0]    bits
);
    logic [DW-1:0] q [NW];
    logic [DW-1:0] d [NW];
    logic [N-1:0]  set_vec, clr_vec;

    assign set_vec = set_en ? (N'(1) << set_idx) : '0;
    assign clr_vec = clr_en ? (N'(1) << clr_idx) : '0;

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam logic [DW-1:0] KEEP = (w == 0) ? ~DW'(1) : '1;
        logic [DW-1:0] m;
        assign m = (wr_en && wr_word == WI_W'(w)) ? wr_mask : '0;
        assign d[w] = ((((q[w] & ~m) | (wr_data & m)) & ~clr_vec[w*DW +: DW])
                      | set_vec[w*DW +: DW]) & KEEP;
        always_ff @(posedge clk) begin
            if (rst) q[w] <= '0;
            else     q[w] <= d[w];
        end
        assign bits[w*DW +: DW] = q[w];
    end

    assign rd_data = q[rd_word];
endmodule

// File: rtl/mif_scan.sv
module mif_scan
    import mif_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [N-1:0]     ready,
    input  logic [LIM_W-1:0] limit,
    output logic [TOP_W-1:0] top_id
);
    logic [N-1:0] elig;

    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig[i] = ready[i] && (LIM_W'(i) < limit) && (i != 0);
    end

    always_comb begin
        top_id = '0;
        for (int i = N - 1; i >= 1; i--) begin
            if (elig[i]) top_id = TOP_W'(i);
        end
    end
endmodule

// File: rtl/msi_intr_file.sv
module msi_intr_file
    import mif_pkg::*;
#(
    parameter int N = 64,
    localparam int NW = N / DW,
    localparam int WI_W = $clog2(NW),
    localparam int ID_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msi_valid,
    input  logic [TOP_W-1:0] msi_id,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_we,
    input  logic [DW-1:0]    reg_wmask,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq
);
    sel_dec_t         dec;
    logic             word_ok;
    logic             deliv_q;
    logic [TOP_W-1:0] thresh_q;
    logic [LIM_W-1:0] limit;
    logic [TOP_W-1:0] top_id;
    logic [N-1:0]     pend_bits, en_bits;
    logic [DW-1:0]    pend_rd, en_rd;
    logic             set_ok, claim;
    logic             irq_q;

    assign dec     = decode_sel(reg_sel);
    assign word_ok = (dec.word < 6'(NW));
    assign set_ok  = msi_valid && (msi_id != '0) && (LIM_W'(msi_id) < LIM_W'(N));
    assign claim   = reg_we && (dec.kind == K_TOP) && (top_id != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            deliv_q  <= 1'b0;
            thresh_q <= '0;
        end else if (reg_we) begin
            if (dec.kind == K_DELIV)
                deliv_q <= (deliv_q & ~reg_wmask[0]) | (reg_wdata[0] & reg_wmask[0]);
            if (dec.kind == K_THRESH)
                thresh_q <= (thresh_q & ~reg_wmask[TOP_W-1:0])
                          | (reg_wdata[TOP_W-1:0] & reg_wmask[TOP_W-1:0]);
        end
    end

    assign limit = ((thresh_q != '0) && (LIM_W'(thresh_q) <= LIM_W'(N)))
                 ? LIM_W'(thresh_q) : LIM_W'(N);

    mif_bitarray #(.N(N)) u_pend (
        .clk(clk), .rst(rst),
        .wr_en(reg_we && dec.kind == K_PEND && word_ok),
        .wr_word(dec.word[WI_W-1:0]), .wr_mask(reg_wmask), .wr_data(reg_wdata),
        .set_en(set_ok), .set_idx(msi_id[ID_W-1:0]),
        .clr_en(claim), .clr_idx(top_id[ID_W-1:0]),
        .rd_word(dec.word[WI_W-1:0]), .rd_data(pend_rd), .bits(pend_bits)
    );

    mif_bitarray #(.N(N)) u_enab (
        .clk(clk), .rst(rst),
        .wr_en(reg_we && dec.kind == K_ENAB && word_ok),
        .wr_word(dec.word[WI_W-1:0]), .wr_mask(reg_wmask), .wr_data(reg_wdata),
        .set_en(1'b0), .set_idx('0),
        .clr_en(1'b0), .clr_idx('0),
        .rd_word(dec.word[WI_W-1:0]), .rd_data(en_rd), .bits(en_bits)
    );

    mif_scan #(.N(N)) u_scan (
        .ready(pend_bits & en_bits), .limit(limit), .top_id(top_id)
    );

    always_comb begin
        unique case (dec.kind)
            K_DELIV:  reg_rdata = DW'(deliv_q);
            K_THRESH: reg_rdata = DW'(thresh_q);
            K_TOP:    reg_rdata = pack_top(top_id);
            K_PEND:   reg_rdata = word_ok ? pend_rd : '0;
            K_ENAB:   reg_rdata = word_ok ? en_rd : '0;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= deliv_q && (top_id != '0);
    end
    assign irq = irq_q;
endmodule

// File: rtl/mif_chk.sv
module mif_chk
    import mif_pkg::*;
#(
    parameter int N = 64,
    localparam int ID_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             deliv_q,
    input logic [TOP_W-1:0] top_id,
    input logic [N-1:0]     pend_bits,
    input logic [N-1:0]     en_bits,
    input logic             reg_we,
    input logic [SEL_W-1:0] reg_sel,
    input logic [DW-1:0]    reg_rdata,
    input logic             msi_valid,
    input logic [TOP_W-1:0] msi_id
);
    logic [ID_W-1:0] top_prev, msi_prev;
    always_ff @(posedge clk) begin
        top_prev <= top_id[ID_W-1:0];
        msi_prev <= msi_id[ID_W-1:0];
    end

    // R9
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(deliv_q && top_id != '0));

    // R2
    id0_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_bits[0] && !en_bits[0]);

    // R5
    top_qualifies_chk: assert property (@(posedge clk) disable iff (rst)
        top_id != '0 |-> pend_bits[top_id[ID_W-1:0]] && en_bits[top_id[ID_W-1:0]]);

    // R7
    claim_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SEL_TOP && top_id != '0
         && !(msi_valid && msi_id == top_id)) |=> !pend_bits[top_prev]);

    // R3
    msi_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && msi_id != '0 && 32'(msi_id) < N) |=> pend_bits[msi_prev]);

    // R8
    deliv_width_chk: assert property (@(posedge clk) disable iff (rst)
        reg_sel == SEL_DELIV |-> reg_rdata[DW-1:1] == '0);
endmodule

bind msi_intr_file mif_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .deliv_q(deliv_q), .top_id(top_id),
    .pend_bits(pend_bits), .en_bits(en_bits), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_id(msi_id)
);

// File: tb/sim_msi_intr_file.sv
`timescale 1ns/1ps
module sim_msi_intr_file;
    logic        clk = 0, rst = 1;
    logic        msi_valid = 0;
    logic [10:0] msi_id = '0;
    logic [7:0]  reg_sel = '0;
    logic        reg_we = 0;
    logic [31:0] reg_wmask = '0, reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    msi_intr_file #(.N(64)) u0 (.*);

    localparam logic [7:0] DLV = 8'h01, THR = 8'h02, TOP = 8'h03;
    localparam logic [7:0] P0 = 8'h40, P1 = 8'h41, E0 = 8'h80, E1 = 8'h81;
    localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OM = 2'd2;
    localparam int NV = 23;
    // {op, sel, mask, data(or id), expected, requirement number}
    localparam logic [109:0] VEC [NV] = '{
        {OW,  E0,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        4'd0},
        {ORD, E0,  32'h0,        32'h0,        32'hFFFFFFFE, 4'd2},  // R2
        {OM,  8'h0,32'h0,        32'd5,        32'h0,        4'd0},
        {OM,  8'h0,32'h0,        32'd3,        32'h0,        4'd0},
        {ORD, P0,  32'h0,        32'h0,        32'h00000028, 4'd3},  // R3
        {ORD, TOP, 32'h0,        32'h0,        32'h00030003, 4'd5},  // R5
        {OW,  P0,  32'h00000008, 32'h0,        32'h0,        4'd0},
        {ORD, P0,  32'h0,        32'h0,        32'h00000020, 4'd4},  // R4
        {ORD, TOP, 32'h0,        32'h0,        32'h00050005, 4'd5},
        {OW,  THR, 32'hFFFFFFFF, 32'd5,        32'h0,        4'd0},
        {ORD, TOP, 32'h0,        32'h0,        32'h0,        4'd6},  // R6
        {OW,  THR, 32'hFFFFFFFF, 32'd6,        32'h0,        4'd0},
        {ORD, TOP, 32'h0,        32'h0,        32'h00050005, 4'd6},
        {OW,  THR, 32'hFFFFFFFF, 32'd0,        32'h0,        4'd0},
        {OW,  TOP, 32'h0,        32'h00001234, 32'h0,        4'd0},
        {ORD, P0,  32'h0,        32'h0,        32'h0,        4'd7},  // R7
        {ORD, TOP, 32'h0,        32'h0,        32'h0,        4'd5},
        {OM,  8'h0,32'h0,        32'd40,       32'h0,        4'd0},
        {ORD, P1,  32'h0,        32'h0,        32'h00000100, 4'd3},
        {ORD, TOP, 32'h0,        32'h0,        32'h0,        4'd5},
        {OW,  E1,  32'h00000100, 32'hFFFFFFFF, 32'h0,        4'd0},
        {ORD, E1,  32'h0,        32'h0,        32'h00000100, 4'd4},
        {ORD, TOP, 32'h0,        32'h0,        32'h00280028, 4'd5}
    };

    task automatic check(input logic [31:0] act, exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] s, input logic [31:0] m, d);
        @(negedge clk);
        reg_sel = s; reg_wmask = m; reg_wdata = d; reg_we = 1;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic msi(input logic [10:0] id);
        @(negedge clk);
        msi_valid = 1; msi_id = id;
        @(negedge clk);
        msi_valid = 0;
    endtask

    task automatic rd(input logic [7:0] s, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_sel = s; reg_we = 0;
        #1 check(reg_rdata, exp, req);
    endtask

    task automatic chk_irq(input logic exp, input string req);
        @(negedge clk);
        #1 check({31'b0, irq}, {31'b0, exp}, req);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1: reset state
        rd(P0, 32'h0, "R1"); rd(E1, 32'h0, "R1");
        rd(THR, 32'h0, "R1"); rd(DLV, 32'h0, "R1");
        rd(TOP, 32'h0, "R1"); chk_irq(1'b0, "R1");

        for (int v = 0; v < NV; v++) begin
            logic [1:0] op; logic [7:0] s; logic [31:0] m, d, e; logic [3:0] r;
            {op, s, m, d, e, r} = VEC[v];
            case (op)
                OW:  wr(s, m, d);
                OM:  msi(d[10:0]);
                default: rd(s, e, $sformatf("R%0d", r));
            endcase
        end

        // R8 and R9: delivery bit and one-cycle request latency
        wr(DLV, 32'hFFFFFFFF, 32'hFFFFFFFF);
        #1 check({31'b0, irq}, 32'h0, "R9");
        chk_irq(1'b1, "R9");
        rd(DLV, 32'h1, "R8");
        wr(TOP, 32'hFFFFFFFF, 32'h0);   // claim 40
        chk_irq(1'b0, "R9");
        rd(P1, 32'h0, "R7");

        // R2: strobe with identity 0, write to bit 0 of pending word 0
        msi(11'd0);
        wr(P0, 32'h1, 32'h1);
        rd(P0, 32'h0, "R2");

        // R3: identity equal to N is ignored
        msi(11'd64);
        rd(P0, 32'h0, "R3"); rd(P1, 32'h0, "R3");

        // R6: threshold above N lets everything through; width is 11 bits
        msi(11'd7);
        wr(THR, 32'hFFFFFFFF, 32'd100);
        rd(TOP, 32'h00070007, "R6");
        wr(THR, 32'hFFFFFFFF, 32'hFFFFFFFF);
        rd(THR, 32'h000007FF, "R6");

        // R7: claim with nothing eligible leaves pending untouched
        wr(THR, 32'hFFFFFFFF, 32'd7);
        rd(TOP, 32'h0, "R6");
        wr(TOP, 32'hFFFFFFFF, 32'hFFFFFFFF);
        rd(P0, 32'h00000080, "R7");

        // R4: during the write cycle the old value is returned
        @(negedge clk);
        reg_sel = P0; reg_wmask = 32'h00000100; reg_wdata = 32'hFFFFFFFF; reg_we = 1;
        #1 check(reg_rdata, 32'h00000080, "R4");
        @(negedge clk) reg_we = 0;
        rd(P0, 32'h00000180, "R4");

        finish_up();
    end
endmodule